// File: doc/BRIEF.md
# Port Operating Mode Resolver with Carrier and Collision Status

This block decides which line technology a 10/100 physical-layer port runs in and produces the medium-side status lines a MAC expects: carrier sense, collision, a duplex indication, an active-low select for an external 100BASE-T4 transceiver and a disable line for an external 10BASE-T transceiver. The operating mode comes from one of two places. When negotiation is switched off, the speed and duplex control bits, together with the external T4 link-good input, force it. When negotiation is on, the mode follows the technology that the negotiation engine reports once that engine reaches its done phase.

Whenever negotiation settles on 100BASE-T4, a supervisor state machine confirms the external link. It has four states. `S_OFF` is idle. `S_T4_WAIT` counts clock cycles while it waits for link-good. `S_T4_UP` means the link is confirmed. `S_RESTART` lasts one cycle and raises the restart request. The transitions are as follows. OFF goes to T4_WAIT when T4 is resolved by negotiation. T4_WAIT goes to T4_UP when link-good is seen. T4_WAIT goes to RESTART when the wait window expires. T4_UP goes to RESTART when link-good falls. RESTART always returns to OFF. Both T4_WAIT and T4_UP fall back to OFF as soon as the negotiated T4 result goes away. The negotiation engine, link pulse timing and all analog functions sit outside this block.

Top module: `link_mode_ctl`

## Requirements
- R1: With `an_enable`=0 the mode is forced, using `mode_sel` codes 0=none, 1=10T half, 2=10T full, 3=100TX half, 4=100TX full, 5=100T4. The forcing rules are: speed=1 with t4_good=1 gives 5. Speed=1 with t4_good=0 gives 4 if duplex=1 and 3 if duplex=0. Speed=0 gives 2 if duplex=1 and 1 if duplex=0, and t4_good is ignored.
- R2: With `an_enable`=1 the mode is taken from `an_tech` (using the same codes 1..5) only while `an_phase`=2 (done). In every other phase (0=held in reset, 1=in progress, 3=treated as in progress), and for `an_tech` values 0, 6 and 7, the mode is 0. The `t4_good` input does not affect the mode in this case.
- R3: `crs` is high when receive activity is present. Transmit activity also raises `crs`, but only when `repeater`=0 (station) and the mode is not half duplex (codes 1, 3 and 5 count as half duplex).
- R4: `col` is high when receive and transmit activity coincide. It is held low in full-duplex modes (codes 2 and 4) and whenever `loopback`=1.
- R5: `duplex` is 0 while negotiation is held in reset (phase 0) and 1 while it is in progress (phase 1 or 3). In phase 2, and whenever negotiation is off, it is 1 exactly for modes 2 and 4.
- R6: `t4_sel_n` is 0 whenever negotiation is off. With negotiation on, it is 0 only when the resolved mode is 5.
- R7: `tbt_link_off` is 1 exactly when the resolved mode is 3, 4 or 5.
- R8: When negotiation resolves T4 and `t4_good` stays low, `restart_req` rises exactly `T4_WAIT_CYC` clock edges after the first edge that sees the T4 result. A forced T4 mode never causes a restart.
- R9: If `t4_good` is high at any edge up to and including the edge at which the window expires, no restart occurs. A later fall of `t4_good` while T4 is still resolved raises `restart_req` one edge after the fall is sampled.
- R10: During reset the outputs hold `mode_sel`=0, `crs`=0, `col`=0, `duplex`=0, `t4_sel_n`=1, `tbt_link_off`=0 and `restart_req`=0, regardless of the inputs. After reset, every status output reflects the inputs sampled at the preceding edge.
- R11: `restart_req` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| an_enable | input | 1 | Negotiation enable control bit |
| spd_100 | input | 1 | Speed select for forced mode (1 = 100 Mb/s) |
| full_dup | input | 1 | Duplex select for forced mode (1 = full) |
| loopback | input | 1 | Loopback control bit |
| repeater | input | 1 | 1 = repeater carrier rule, 0 = station |
| an_phase | input | 2 | Negotiation phase: 0 reset, 1 active, 2 done |
| an_tech | input | 3 | Negotiated technology code (1..5) |
| t4_good | input | 1 | External T4 link-good indication |
| rx_act | input | 1 | Receive activity |
| tx_act | input | 1 | Transmit activity |
| mode_sel | output | 3 | Resolved operating mode code |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| duplex | output | 1 | Duplex / negotiation indication |
| t4_sel_n | output | 1 | Active-low external T4 transceiver select |
| tbt_link_off | output | 1 | 1 = external 10BASE-T transceiver disabled |
| restart_req | output | 1 | One-cycle negotiation restart request |

## Verification
Every status output is registered once, so it appears one edge after its inputs are sampled. The restart pulse is different: it shows up `T4_WAIT_CYC` edges after the first edge that sees a negotiated T4 result, or one edge after a sampled drop of link-good. The bench changes its inputs 1 ns after a rising edge and compares the outputs 1 ns after the next rising edge. For the timeout, it counts edges one at a time and expects the pulse on exactly the computed edge and on no other. Two sweeps compute the expected value of every output for each input pattern. One covers all forced-mode combinations and the other covers all negotiated phase, technology and activity combinations.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    typedef enum logic [2:0] {
        MD_NONE = 3'd0,
        MD_10H  = 3'd1,
        MD_10F  = 3'd2,
        MD_TXH  = 3'd3,
        MD_TXF  = 3'd4,
        MD_T4   = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        PH_RESET  = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_DONE   = 2'd2,
        PH_SPARE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        S_OFF     = 2'd0,
        S_T4_WAIT = 2'd1,
        S_T4_UP   = 2'd2,
        S_RESTART = 2'd3
    } t4_state_e;

    function automatic logic mode_is_full(mode_e m);
        return (m == MD_10F) || (m == MD_TXF);
    endfunction

    function automatic logic mode_is_half(mode_e m);
        return (m == MD_10H) || (m == MD_TXH) || (m == MD_T4);
    endfunction

    function automatic logic mode_uses_local(mode_e m);
        return (m == MD_TXH) || (m == MD_TXF) || (m == MD_T4);
    endfunction

endpackage

// File: rtl/lmc_mode_resolve.sv
module lmc_mode_resolve
    import lmc_pkg::*;
(
    input  logic       an_enable,
    input  logic       spd_100,
    input  logic       full_dup,
    input  logic       t4_good,
    input  logic [1:0] an_phase,
    input  logic [2:0] an_tech,
    output mode_e      mode,
    output logic       neg_t4
);

    logic  an_done;
    mode_e forced_mode;
    mode_e nego_mode;

    assign an_done = (an_phase == PH_DONE);

    // forced table (R1)
    always_comb begin
        unique case ({spd_100, full_dup})
            2'b11:   forced_mode = t4_good ? MD_T4 : MD_TXF;
            2'b10:   forced_mode = t4_good ? MD_T4 : MD_TXH;
            2'b01:   forced_mode = MD_10F;
            default: forced_mode = MD_10H;
        endcase
    end

    // negotiated result decode (R2)
    always_comb begin
        unique case (an_tech)
            3'd1:    nego_mode = MD_10H;
            3'd2:    nego_mode = MD_10F;
            3'd3:    nego_mode = MD_TXH;
            3'd4:    nego_mode = MD_TXF;
            3'd5:    nego_mode = MD_T4;
            default: nego_mode = MD_NONE;
        endcase
    end

    always_comb begin
        if (!an_enable) begin
            mode = forced_mode;
        end else if (an_done) begin
            mode = nego_mode;
        end else begin
            mode = MD_NONE;
        end
    end

    assign neg_t4 = an_enable && an_done && (nego_mode == MD_T4);

endmodule

// File: rtl/lmc_t4_watch.sv
module lmc_t4_watch
    import lmc_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 21_875_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic neg_t4,
    input  logic t4_good,
    output logic restart
);

    localparam int unsigned CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    t4_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_OFF: begin
                cnt_d = '0;
                if (neg_t4) state_d = S_T4_WAIT;
            end
            S_T4_WAIT: begin
                if (!neg_t4) begin
                    state_d = S_OFF;
                end else if (t4_good) begin
                    state_d = S_T4_UP;
                end else if (cnt_q == LAST) begin
                    state_d = S_RESTART;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_T4_UP: begin
                if (!neg_t4) begin
                    state_d = S_OFF;
                end else if (!t4_good) begin
                    state_d = S_RESTART;
                end
            end
            S_RESTART: begin
                state_d = S_OFF;
            end
            default: state_d = S_OFF;
        endcase
    end

    always_comb begin
        restart = (state_q == S_RESTART);
    end

endmodule

// File: rtl/lmc_mii_status.sv
module lmc_mii_status
    import lmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mode_e      mode,
    input  logic       an_enable,
    input  logic [1:0] an_phase,
    input  logic       repeater,
    input  logic       loopback,
    input  logic       rx_act,
    input  logic       tx_act,
    output logic [2:0] mode_q,
    output logic       crs_q,
    output logic       col_q,
    output logic       dup_q,
    output logic       t4n_q,
    output logic       tbt_q
);

    logic full, half;
    logic crs_d, col_d, dup_d, t4n_d, tbt_d;

    assign full = mode_is_full(mode);
    assign half = mode_is_half(mode);

    always_comb begin
        crs_d = rx_act || (tx_act && !repeater && !half);
        col_d = rx_act && tx_act && !full && !loopback;
        tbt_d = mode_uses_local(mode);
        if (!an_enable) begin
            dup_d = full;
            t4n_d = 1'b0;
        end else begin
            t4n_d = (mode != MD_T4);
            unique case (an_phase)
                PH_RESET: dup_d = 1'b0;
                PH_DONE:  dup_d = full;
                default:  dup_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_NONE;
            crs_q  <= 1'b0;
            col_q  <= 1'b0;
            dup_q  <= 1'b0;
            t4n_q  <= 1'b1;
            tbt_q  <= 1'b0;
        end else begin
            mode_q <= mode;
            crs_q  <= crs_d;
            col_q  <= col_d;
            dup_q  <= dup_d;
            t4n_q  <= t4n_d;
            tbt_q  <= tbt_d;
        end
    end

endmodule

// File: rtl/link_mode_ctl.sv
module link_mode_ctl
    import lmc_pkg::*;
#(
    parameter int unsigned T4_WAIT_CYC = 21_875_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       an_enable,
    input  logic       spd_100,
    input  logic       full_dup,
    input  logic       loopback,
    input  logic       repeater,
    input  logic [1:0] an_phase,
    input  logic [2:0] an_tech,
    input  logic       t4_good,
    input  logic       rx_act,
    input  logic       tx_act,
    output logic [2:0] mode_sel,
    output logic       crs,
    output logic       col,
    output logic       duplex,
    output logic       t4_sel_n,
    output logic       tbt_link_off,
    output logic       restart_req
);

    mode_e mode_now;
    logic  neg_t4;

    lmc_mode_resolve u_resolve (
        .an_enable (an_enable),
        .spd_100   (spd_100),
        .full_dup  (full_dup),
        .t4_good   (t4_good),
        .an_phase  (an_phase),
        .an_tech   (an_tech),
        .mode      (mode_now),
        .neg_t4    (neg_t4)
    );

    lmc_t4_watch #(.WAIT_CYC(T4_WAIT_CYC)) u_t4 (
        .clk     (clk),
        .rst_n   (rst_n),
        .neg_t4  (neg_t4),
        .t4_good (t4_good),
        .restart (restart_req)
    );

    lmc_mii_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_now),
        .an_enable (an_enable),
        .an_phase  (an_phase),
        .repeater  (repeater),
        .loopback  (loopback),
        .rx_act    (rx_act),
        .tx_act    (tx_act),
        .mode_q    (mode_sel),
        .crs_q     (crs),
        .col_q     (col),
        .dup_q     (duplex),
        .t4n_q     (t4_sel_n),
        .tbt_q     (tbt_link_off)
    );

endmodule

// File: rtl/link_mode_ctl_chk.sv
module link_mode_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       an_enable,
    input logic       loopback,
    input logic       rx_act,
    input logic       tx_act,
    input logic [2:0] mode_sel,
    input logic       crs,
    input logic       col,
    input logic       t4_sel_n,
    input logic       tbt_link_off,
    input logic       restart_req
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    assert_restart_needs_nego_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && restart_req) |-> $past(an_enable));

    assert_col_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && col) |-> $past(rx_act && tx_act && !loopback));

    assert_crs_needs_activity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && crs) |-> $past(rx_act || tx_act));

    assert_t4_sel_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(an_enable)) |-> !t4_sel_n);

    assert_tbt_off_modes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tbt_link_off |-> (mode_sel >= 3'd3 && mode_sel <= 3'd5));

endmodule

bind link_mode_ctl link_mode_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .an_enable    (an_enable),
    .loopback     (loopback),
    .rx_act       (rx_act),
    .tx_act       (tx_act),
    .mode_sel     (mode_sel),
    .crs          (crs),
    .col          (col),
    .t4_sel_n     (t4_sel_n),
    .tbt_link_off (tbt_link_off),
    .restart_req  (restart_req)
);

// File: tb/link_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module link_mode_ctl_tb_top;

    localparam int WAIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       an_enable = 1'b0, spd_100 = 1'b0, full_dup = 1'b0, loopback = 1'b0;
    logic       repeater = 1'b0, t4_good = 1'b0, rx_act = 1'b0, tx_act = 1'b0;
    logic [1:0] an_phase = 2'd0;
    logic [2:0] an_tech = 3'd0;
    logic [2:0] mode_sel;
    logic       crs, col, duplex, t4_sel_n, tbt_link_off, restart_req;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    link_mode_ctl #(.T4_WAIT_CYC(WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .spd_100(spd_100),
        .full_dup(full_dup), .loopback(loopback), .repeater(repeater),
        .an_phase(an_phase), .an_tech(an_tech), .t4_good(t4_good),
        .rx_act(rx_act), .tx_act(tx_act), .mode_sel(mode_sel), .crs(crs),
        .col(col), .duplex(duplex), .t4_sel_n(t4_sel_n),
        .tbt_link_off(tbt_link_off), .restart_req(restart_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int exp_mode();
        if (!an_enable) begin
            if (spd_100) return t4_good ? 5 : (full_dup ? 4 : 3);
            return full_dup ? 2 : 1;
        end
        if (an_phase == 2'd2 && an_tech >= 3'd1 && an_tech <= 3'd5) return int'(an_tech);
        return 0;
    endfunction

    task automatic check_all();
        int  m;
        bit  fl, hf, e_dup, e_t4n;
        m  = exp_mode();
        fl = (m == 2) || (m == 4);
        hf = (m == 1) || (m == 3) || (m == 5);
        if (!an_enable) begin
            e_dup = fl;
            e_t4n = 1'b0;
        end else begin
            e_t4n = (m != 5);
            e_dup = (an_phase == 2'd0) ? 1'b0 : (an_phase == 2'd2) ? fl : 1'b1;
        end
        chk(an_enable ? "R2 mode" : "R1 mode", int'(mode_sel), m);
        chk("R3 crs", int'(crs), int'(rx_act | (tx_act & !repeater & !hf)));
        chk("R4 col", int'(col), int'(rx_act & tx_act & !fl & !loopback));
        chk("R5 duplex", int'(duplex), int'(e_dup));
        chk("R6 t4_sel_n", int'(t4_sel_n), int'(e_t4n));
        chk("R7 tbt_link_off", int'(tbt_link_off), int'(m >= 3 && m <= 5));
        chk("R8 no restart in sweep", int'(restart_req), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        // R10: reset state with busy inputs
        an_enable = 1'b1; an_phase = 2'd2; an_tech = 3'd4;
        rx_act = 1'b1; tx_act = 1'b1;
        tick();
        tick();
        chk("R10 reset mode", int'(mode_sel), 0);
        chk("R10 reset crs", int'(crs), 0);
        chk("R10 reset col", int'(col), 0);
        chk("R10 reset duplex", int'(duplex), 0);
        chk("R10 reset t4_sel_n", int'(t4_sel_n), 1);
        chk("R10 reset tbt", int'(tbt_link_off), 0);
        chk("R10 reset restart", int'(restart_req), 0);
        rst_n = 1'b1;
        tick();
        check_all();  // R10: one-edge latency after release

        // R1 sweep: forced modes
        for (int i = 0; i < 128; i++) begin
            an_enable = 1'b0;
            spd_100 = i[6]; full_dup = i[5]; t4_good = i[4];
            loopback = i[3]; repeater = i[2]; rx_act = i[1]; tx_act = i[0];
            tick();
            check_all();
        end

        // R2 sweep: negotiated results
        t4_good = 1'b1;
        for (int i = 0; i < 512; i++) begin
            an_enable = 1'b1;
            an_phase = i[8:7]; an_tech = i[6:4];
            repeater = i[3]; loopback = i[2]; rx_act = i[1]; tx_act = i[0];
            tick();
            check_all();
        end

        // R8 / R11: timeout with link-good low
        do_reset();
        an_enable = 1'b1; an_phase = 2'd2; an_tech = 3'd5; t4_good = 1'b0;
        rx_act = 1'b0; tx_act = 1'b0;
        for (int j = 1; j <= WAIT; j++) begin
            tick();
            chk("R8 before window end", int'(restart_req), 0);
        end
        tick();
        chk("R8 restart at window end", int'(restart_req), 1);
        chk("R6 t4_sel_n low in T4", int'(t4_sel_n), 0);
        tick();
        chk("R11 single cycle pulse", int'(restart_req), 0);
        an_phase = 2'd1;
        tick();
        tick();
        chk("R8 idle after leaving T4", int'(restart_req), 0);

        // R9: link-good arrives on the last accepted edge, then drops
        do_reset();
        an_enable = 1'b1; an_phase = 2'd2; an_tech = 3'd5; t4_good = 1'b0;
        for (int j = 1; j <= WAIT; j++) begin
            tick();
        end
        t4_good = 1'b1;
        tick();
        chk("R9 good on last edge", int'(restart_req), 0);
        for (int j = 0; j < WAIT + 4; j++) begin
            tick();
            chk("R9 confirmed link holds", int'(restart_req), 0);
        end
        t4_good = 1'b0;
        tick();
        chk("R9 drop restarts", int'(restart_req), 1);
        tick();
        chk("R11 drop pulse single", int'(restart_req), 0);

        // R8: forced T4 never restarts
        do_reset();
        an_enable = 1'b0; spd_100 = 1'b1; full_dup = 1'b1; t4_good = 1'b1;
        tick();
        chk("R1 forced T4 mode", int'(mode_sel), 5);
        t4_good = 1'b0;
        for (int j = 0; j < WAIT + 4; j++) begin
            tick();
            chk("R8 forced T4 no restart", int'(restart_req), 0);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule